// File: doc/BRIEF.md
# Stepped Sweep Generator with Dwell Markers

This block drives a synthesizer through a repeating staircase of tuning words, so that an oscilloscope can show a frequency response. When it starts, it takes a centre tuning word, an offset tuning word and a step-count mode. It begins at centre minus offset. Each later step adds a fixed binary increment, which is the offset shifted right by 7 or by 8. At every step it presents a 40-bit word (a constant control byte above the 32-bit tuning word) together with a ramp count for a DAC that drives the horizontal axis, and raises a one-cycle load strobe for the downstream serializers.

Every step is held for a base dwell. At three marker positions (a quarter, half and three quarters of the way through the sweep) the step is held for an extra dwell, so the trace is brighter there. A step does not end until the serializer reports that it is ready. The sweep repeats for as long as enable stays high.

Top module: `sweep_marker_gen`

## Requirements
- R1: While `rst` is high, and after it until the first step, `load_stb` is 0, `ramp_val` is 0 and `dds_word` is 0x01 followed by 32 zero bits.
- R2: Bits 39:32 of `dds_word` are always 0x01. Bits 31:0 carry the current tuning word.
- R3: On the first step after enable rises, the tuning word is `centre_tw - offset_tw` (modulo 2^32) and `ramp_val` is 1.
- R4: Each later step adds an increment to the previous tuning word, modulo 2^32. The increment is `offset_tw >> 7` when `mode_long`=0 and `offset_tw >> 8` when `mode_long`=1.
- R5: `ramp_val` rises by one on every step and changes in the same cycle as the tuning word and `load_stb`.
- R6: A sweep has 128 steps when `mode_long`=0 and 255 steps when `mode_long`=1. After the last step, the next step returns to the start word with `ramp_val`=1.
- R7: `marker_flag` is 1 exactly on the steps whose ramp value is q, 2q or 3q, where q=32 when `mode_long`=0 and q=64 when `mode_long`=1.
- R8: With `ser_ready` held high, the distance from one strobe to the next is BASE_DWELL cycles. After a marker step it is BASE_DWELL+MARK_DWELL cycles.
- R9: `load_stb` is high for a single cycle per step, and `dds_word` does not change in cycles where `load_stb` is low.
- R10: If `ser_ready` is low when the dwell ends, no new step is issued. The step comes in the cycle after the first clock edge at which `ser_ready` is seen high.
- R11: While `enable` is low, no strobe is issued. When `enable` rises again, the sweep restarts at R3 using the inputs present at that moment.
- R12: Changes to `centre_tw`, `offset_tw` or `mode_long` while a sweep is running have no effect on the words produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the sweep while high |
| mode_long | input | 1 | 0: 128 steps, shift 7; 1: 255 steps, shift 8 |
| centre_tw | input | 32 | Centre tuning word, sampled at start |
| offset_tw | input | 32 | Offset tuning word, sampled at start |
| ser_ready | input | 1 | Serializers can accept a new word |
| load_stb | output | 1 | One-cycle strobe marking a new step |
| dds_word | output | 40 | Control byte 0x01 followed by the tuning word |
| ramp_val | output | 8 | Step number, starting at 1 |
| marker_flag | output | 1 | Current step is a marker position |

## Verification
The hardest case to reach is a stall that overlaps the exact cycle in which the dwell counter expires. The bench reaches it by waiting for a strobe, pulling `ser_ready` low well before the dwell ends, and holding it low long enough to see that no further strobe appears. It then raises `ser_ready` and expects the strobe one clock later. A second hard case is a start word below zero (an offset larger than the centre). The bench covers this with a long-mode sweep and checks every step through one full wrap. Input changes while a sweep is running are also tested, and the words that follow are compared against the values latched when the sweep started.

// File: rtl/sweep_pkg.sv
package sweep_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DWELL = 2'd1,
    ST_WAIT  = 2'd2
  } sweep_state_e;

  localparam int CTRL_W = 8;
endpackage

// File: rtl/sweep_step_calc.sv
// Start point and per-step increment derived from the centre and offset words.
module sweep_step_calc #(
  parameter int TW_W        = 32,
  parameter int SHIFT_SHORT = 7,
  parameter int SHIFT_LONG  = 8
) (
  input  logic [TW_W-1:0] centre,
  input  logic [TW_W-1:0] offset,
  input  logic            long_mode,
  output logic [TW_W-1:0] start_tw,
  output logic [TW_W-1:0] inc_tw
);
  always_comb begin
    start_tw = centre - offset;
    if (long_mode) inc_tw = offset >> SHIFT_LONG;
    else           inc_tw = offset >> SHIFT_SHORT;
  end
endmodule

// File: rtl/sweep_marker_decode.sv
// Flags the quarter, half and three-quarter positions of the sweep.
module sweep_marker_decode #(
  parameter int RW          = 8,
  parameter int SHIFT_SHORT = 7,
  parameter int SHIFT_LONG  = 8,
  parameter int N_MARK      = 3
) (
  input  logic [RW-1:0] ramp,
  input  logic          long_mode,
  output logic          is_marker
);
  localparam int Q_SHORT = 1 << (SHIFT_SHORT - 2);
  localparam int Q_LONG  = 1 << (SHIFT_LONG - 2);

  logic [N_MARK-1:0] hit;

  for (genvar i = 0; i < N_MARK; i++) begin : g_mark
    assign hit[i] = long_mode ? (ramp == RW'((i + 1) * Q_LONG))
                              : (ramp == RW'((i + 1) * Q_SHORT));
  end

  assign is_marker = |hit;
endmodule

// File: rtl/sweep_dwell_timer.sv
// Down counter that holds each step; done is high when the count reaches zero.
module sweep_dwell_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/sweep_marker_gen.sv
// Stepped tuning-word sweep with marker dwells for a scope display.
module sweep_marker_gen #(
  parameter int          TW_W        = 32,
  parameter int          SHIFT_SHORT = 7,
  parameter int          SHIFT_LONG  = 8,
  parameter int          BASE_DWELL  = 16,
  parameter int          MARK_DWELL  = 64,
  parameter logic [7:0]  CTRL_BYTE   = 8'h01,
  localparam int         RW          = SHIFT_LONG,
  localparam int         WORD_W      = sweep_pkg::CTRL_W + TW_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              mode_long,
  input  logic [TW_W-1:0]   centre_tw,
  input  logic [TW_W-1:0]   offset_tw,
  input  logic              ser_ready,
  output logic              load_stb,
  output logic [WORD_W-1:0] dds_word,
  output logic [RW-1:0]     ramp_val,
  output logic              marker_flag
);
  import sweep_pkg::*;

  localparam int            LEN_MAX    = BASE_DWELL + MARK_DWELL;
  localparam int            CW         = $clog2(LEN_MAX + 1);
  localparam logic [RW-1:0] LAST_SHORT = RW'(1 << SHIFT_SHORT);
  localparam logic [RW-1:0] LAST_LONG  = RW'((1 << SHIFT_LONG) - 1);

  sweep_state_e    state;
  logic [TW_W-1:0] cur_tw, start_q, inc_q;
  logic [TW_W-1:0] start_c, inc_c;
  logic [RW-1:0]   ramp_q;
  logic            long_q;
  logic            stb_q, mark_q;

  logic [RW-1:0]   last_ramp;
  logic            wrap;
  logic [RW-1:0]   next_ramp;
  logic            mode_sel;
  logic            next_mark;
  logic            advance, start_now;
  logic            tmr_load, tmr_done;
  logic [CW-1:0]   tmr_val;

  sweep_step_calc #(
    .TW_W(TW_W), .SHIFT_SHORT(SHIFT_SHORT), .SHIFT_LONG(SHIFT_LONG)
  ) calc_i (
    .centre(centre_tw), .offset(offset_tw), .long_mode(mode_long),
    .start_tw(start_c), .inc_tw(inc_c)
  );

  assign last_ramp = long_q ? LAST_LONG : LAST_SHORT;
  assign wrap      = (ramp_q == last_ramp);
  assign start_now = enable && (state == ST_IDLE);
  assign advance   = enable && ser_ready &&
                     ((state == ST_WAIT) || ((state == ST_DWELL) && tmr_done && !stb_q));
  assign next_ramp = (start_now || wrap) ? RW'(1) : ramp_q + RW'(1);
  assign mode_sel  = start_now ? mode_long : long_q;

  sweep_marker_decode #(
    .RW(RW), .SHIFT_SHORT(SHIFT_SHORT), .SHIFT_LONG(SHIFT_LONG), .N_MARK(3)
  ) mark_i (
    .ramp(next_ramp), .long_mode(mode_sel), .is_marker(next_mark)
  );

  assign tmr_load = start_now || advance;
  assign tmr_val  = CW'(BASE_DWELL - 1) + (next_mark ? CW'(MARK_DWELL) : CW'(0));

  sweep_dwell_timer #(.CW(CW)) tmr_i (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cur_tw  <= '0;
      start_q <= '0;
      inc_q   <= '0;
      ramp_q  <= '0;
      long_q  <= 1'b0;
      stb_q   <= 1'b0;
      mark_q  <= 1'b0;
    end else if (!enable) begin
      state <= ST_IDLE;
      stb_q <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          start_q <= start_c;
          inc_q   <= inc_c;
          long_q  <= mode_long;
          cur_tw  <= start_c;
          ramp_q  <= next_ramp;
          mark_q  <= next_mark;
          stb_q   <= 1'b1;
          state   <= ST_DWELL;
        end
        ST_DWELL, ST_WAIT: begin
          if (advance) begin
            cur_tw <= wrap ? start_q : cur_tw + inc_q;
            ramp_q <= next_ramp;
            mark_q <= next_mark;
            stb_q  <= 1'b1;
            state  <= ST_DWELL;
          end else if (state == ST_DWELL && tmr_done && !stb_q) begin
            state <= ST_WAIT;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign load_stb    = stb_q;
  assign dds_word    = {CTRL_BYTE, cur_tw};
  assign ramp_val    = ramp_q;
  assign marker_flag = mark_q;
endmodule

// File: rtl/sweep_marker_chk.sv
// Temporal checks on the sweep generator, bound to the top module.
module sweep_marker_chk #(
  parameter int TW_W = 32,
  parameter int RW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            enable,
  input logic            ser_ready,
  input logic            load_stb,
  input logic [39:0]     dds_word,
  input logic [RW-1:0]   ramp_val,
  input logic [TW_W-1:0] inc
);
  // R9: strobe lasts a single cycle
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    load_stb |=> !load_stb);

  // R9: word holds between strobes
  a_r9_word_stable: assert property (@(posedge clk) disable iff (rst)
    !load_stb |-> $stable(dds_word));

  // R5: ramp counts up by one on non-initial steps
  a_r5_ramp_step: assert property (@(posedge clk) disable iff (rst)
    (load_stb && ramp_val != RW'(1)) |-> ramp_val == $past(ramp_val) + RW'(1));

  // R4: tuning word advances by the latched increment
  a_r4_step_add: assert property (@(posedge clk) disable iff (rst)
    (load_stb && ramp_val != RW'(1)) |-> dds_word[31:0] == $past(dds_word[31:0]) + inc);

  // R10: a mid-sweep step needs ready at the previous edge
  a_r10_wait_ready: assert property (@(posedge clk) disable iff (rst)
    (load_stb && ramp_val != RW'(1)) |-> $past(ser_ready));

  // R11: no strobe follows a cycle with enable low
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !load_stb);
endmodule

bind sweep_marker_gen sweep_marker_chk #(.TW_W(TW_W), .RW(RW)) chk_i (
  .clk(clk), .rst(rst), .enable(enable), .ser_ready(ser_ready),
  .load_stb(load_stb), .dds_word(dds_word), .ramp_val(ramp_val), .inc(inc_q)
);

// File: tb/sweep_marker_gen_tb_top.sv
module sweep_marker_gen_tb_top;
  localparam int BASE = 2;
  localparam int MARK = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b0;
  logic        mode_long = 1'b0;
  logic [31:0] centre_tw = '0;
  logic [31:0] offset_tw = '0;
  logic        ser_ready = 1'b1;
  logic        load_stb;
  logic [39:0] dds_word;
  logic [7:0]  ramp_val;
  logic        marker_flag;

  always #2 clk = ~clk;

  sweep_marker_gen #(.BASE_DWELL(BASE), .MARK_DWELL(MARK)) dut_i (
    .clk(clk), .rst(rst), .enable(enable), .mode_long(mode_long),
    .centre_tw(centre_tw), .offset_tw(offset_tw), .ser_ready(ser_ready),
    .load_stb(load_stb), .dds_word(dds_word), .ramp_val(ramp_val),
    .marker_flag(marker_flag)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int stb_cnt = 0;
  int last_cyc = 0;
  int exp_gap = 0;
  bit mon_on = 0;
  bit chk_gap = 1;
  bit first = 1;
  bit prev_stb = 0;
  logic [31:0] exp_start, exp_inc;
  int exp_ramp, exp_last, exp_q;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic bit is_mark(input int r);
    return (r == exp_q) || (r == 2 * exp_q) || (r == 3 * exp_q);
  endfunction

  // Step monitor: compares each strobe with the arithmetic model
  always @(negedge clk) begin
    cyc++;
    if (mon_on && load_stb) begin
      logic [31:0] e_tw;
      e_tw = exp_start + 32'(exp_ramp - 1) * exp_inc;
      stb_cnt++;
      check(!prev_stb, "R9 pulse", 1, 0);
      check(dds_word[39:32] == 8'h01, "R2 ctrl", dds_word[39:32], 8'h01);
      check(dds_word[31:0] == e_tw,
            first ? "R3 start" : (exp_ramp == 1 ? "R6 wrap" : "R4 step"), dds_word[31:0], e_tw);
      check(ramp_val == 8'(exp_ramp), "R5 ramp", ramp_val, exp_ramp);
      check(marker_flag == is_mark(exp_ramp), "R7 marker", marker_flag, is_mark(exp_ramp));
      if (!first && chk_gap)
        check(cyc - last_cyc == exp_gap, "R8 gap", cyc - last_cyc, exp_gap);
      exp_gap  = BASE + (is_mark(exp_ramp) ? MARK : 0);
      last_cyc = cyc;
      first    = 0;
      exp_ramp = (exp_ramp == exp_last) ? 1 : exp_ramp + 1;
    end
    prev_stb = load_stb;
  end

  // Watchdog
  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  task automatic start_sweep(input logic [31:0] c, input logic [31:0] o, input bit lm);
    @(negedge clk); #1;
    centre_tw = c; offset_tw = o; mode_long = lm;
    exp_start = c - o;
    exp_inc   = lm ? (o >> 8) : (o >> 7);
    exp_last  = lm ? 255 : 128;
    exp_q     = lm ? 64 : 32;
    exp_ramp  = 1;
    first     = 1;
    mon_on    = 1;
    enable    = 1;
  endtask

  task automatic stop_sweep();
    int n0;
    @(negedge clk); #1;
    enable = 0;
    @(negedge clk); #1;
    n0 = stb_cnt;
    repeat (12) @(negedge clk);
    #1;
    check(stb_cnt == n0, "R11 stopped", stb_cnt, n0);
    check(load_stb == 0, "R11 strobe low", load_stb, 0);
    mon_on = 0;
  endtask

  initial begin
    int n0;
    repeat (3) @(negedge clk);
    check(load_stb == 0, "R1 strobe", load_stb, 0);
    check(ramp_val == 0, "R1 ramp", ramp_val, 0);
    check(dds_word == 40'h01_0000_0000, "R1 word", dds_word, 40'h01_0000_0000);
    rst = 0;
    repeat (3) @(negedge clk);
    check(load_stb == 0 && ramp_val == 0, "R1 after reset", ramp_val, 0);

    // short mode, with input changes mid-sweep (R12); 1.5 passes covers wrap (R6)
    start_sweep(32'h1000_0000, 32'h0012_3456, 0);
    repeat (60) @(negedge clk);
    #1 centre_tw = 32'hDEAD_BEEF; offset_tw = 32'h7777_0000; mode_long = 1;  // R12
    repeat (340) @(negedge clk);
    stop_sweep();

    // long mode, negative start, wraps modulo 2^32
    start_sweep(32'h0000_0100, 32'h0100_0000, 1);
    repeat (300) @(negedge clk);
    // stall across the dwell end (R10)
    @(negedge clk);
    while (!load_stb) @(negedge clk);
    #1;
    n0 = stb_cnt;
    chk_gap = 0;
    ser_ready = 0;
    repeat (20) @(negedge clk);
    #1;
    check(stb_cnt == n0, "R10 stalled", stb_cnt, n0);
    ser_ready = 1;
    @(negedge clk);
    check(load_stb == 1, "R10 resume", load_stb, 1);
    #1 chk_gap = 1;
    repeat (400) @(negedge clk);
    stop_sweep();

    // small offset: zero increment, restart after stop uses new inputs (R11)
    start_sweep(32'h0000_5000, 32'h0000_0050, 0);
    repeat (300) @(negedge clk);
    stop_sweep();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule